// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Unit

This unit gathers the interrupt conditions of an SPI controller into one seven-bit status word, gates that word with a mask, and drives a single level-sensitive interrupt line. Each status bit is set by an input from the controller's datapath. Some inputs are one-cycle event strobes, such as a mode fault. Others are live FIFO conditions: transmit FIFO below its watermark, transmit FIFO full, and receive FIFO not empty. Software clears a status bit by writing a one to that bit of the status register.

Software changes the mask through two write-only registers. Ones written to the enable register set mask bits, and ones written to the disable register clear them. Software therefore never has to read the mask and write it back. A separate read-only register returns the current mask. All registers share a simple single-cycle port: an address, a write strobe, write data, and combinational read data.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset, the status and the mask are both zero and `irq_o` is low.
- R2: A high level on `src_i[b]` at a clock edge sets status bit b. The bit then holds until software clears it. Reading offset 0x04 returns the status in bits [6:0], with zeros above. Status bit 1 is mode fault.
- R3: Writing to offset 0x04 clears every status bit written as one and leaves the bits written as zero unchanged.
- R4: When a source is high in the same cycle as a clear of its bit, the set wins and the bit stays one.
- R5: A level source (bit 2 TX below watermark, bit 3 TX full, bit 4 RX not empty) keeps its status bit set through clears while the condition persists. Once the condition drops, a clear removes the bit.
- R6: Writing to offset 0x08 sets each mask bit written as one and leaves the other mask bits unchanged.
- R7: Writing to offset 0x0C clears each mask bit written as one and leaves the other mask bits unchanged.
- R8: Reading offset 0x10 returns the mask in bits [6:0], with zeros above.
- R9: Reads of 0x08, 0x0C and any unmapped offset return zero. Writes to 0x10 leave the mask unchanged.
- R10: `irq_o` is high exactly when some bit is set in both status and mask. It follows the registers in the same cycle they change.
- R11: Write-data bits above bit 6 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte offset |
| wr_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| src_i | input | 7 | Interrupt source strobes and levels |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets a source that fires in the same cycle as its clear. A design that lets the clear win there silently loses an event. It also holds a level source high through a clear. A design that ignored the live level would drop a FIFO condition that still exists. The bench checks that enable and disable writes touch only the bits written as one, and that writes to the read-only mask offset and to write-data bits above bit 6 change nothing. Mix-ups between set and clear, or between offsets, show up as a wrong mask readback or a wrong interrupt level.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned IRQ_NUM_SRC = 7;
  localparam int unsigned REG_ADDR_W  = 6;
  localparam int unsigned REG_DATA_W  = 32;

  localparam logic [REG_ADDR_W-1:0] OFF_STATUS  = 6'h04;
  localparam logic [REG_ADDR_W-1:0] OFF_ENABLE  = 6'h08;
  localparam logic [REG_ADDR_W-1:0] OFF_DISABLE = 6'h0C;
  localparam logic [REG_ADDR_W-1:0] OFF_MASK    = 6'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_DISABLE,
    SEL_MASK
  } reg_sel_e;
endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = REG_ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output reg_sel_e          sel_o,
  output logic              stat_clr_o,
  output logic              mask_set_o,
  output logic              mask_clr_o
);
  always_comb begin
    unique case (addr_i)
      OFF_STATUS:  sel_o = SEL_STATUS;
      OFF_ENABLE:  sel_o = SEL_ENABLE;
      OFF_DISABLE: sel_o = SEL_DISABLE;
      OFF_MASK:    sel_o = SEL_MASK;
      default:     sel_o = SEL_NONE;
    endcase
  end

  // mask offset is read-only: no write strobe derived from it
  assign stat_clr_o = wr_i && (sel_o == SEL_STATUS);
  assign mask_set_o = wr_i && (sel_o == SEL_ENABLE);
  assign mask_clr_o = wr_i && (sel_o == SEL_DISABLE);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clr_en_i,
  input  logic [NUM_SRC-1:0] clr_bits_i,
  output logic [NUM_SRC-1:0] status_o
);
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q <= 1'b0;
      end else if (src_i[b]) begin
        bit_q <= 1'b1;  // set beats a same-cycle clear
      end else if (clr_en_i && clr_bits_i[b]) begin
        bit_q <= 1'b0;
      end
    end
    assign status_o[b] = bit_q;
  end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_en_i,
  input  logic               clr_en_i,
  input  logic [NUM_SRC-1:0] bits_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q, set_v, clr_v;

  assign set_v = set_en_i ? bits_i : '0;
  assign clr_v = clr_en_i ? bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_v) & ~clr_v;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = IRQ_NUM_SRC,
  parameter int unsigned ADDR_W  = REG_ADDR_W,
  parameter int unsigned DATA_W  = REG_DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  reg_sel_e           sel;
  logic               stat_clr, mask_set, mask_clr;
  logic [NUM_SRC-1:0] wbits, status_q, mask_q;

  assign wbits = wdata_i[NUM_SRC-1:0];

  spi_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .sel_o     (sel),
    .stat_clr_o(stat_clr),
    .mask_set_o(mask_set),
    .mask_clr_o(mask_clr)
  );

  spi_irq_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src_i),
    .clr_en_i  (stat_clr),
    .clr_bits_i(wbits),
    .status_o  (status_q)
  );

  spi_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_en_i(mask_set),
    .clr_en_i(mask_clr),
    .bits_i  (wbits),
    .mask_o  (mask_q)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_o = {{PAD_W{1'b0}}, status_q};
      SEL_MASK:   rdata_o = {{PAD_W{1'b0}}, mask_q};
      default:    rdata_o = '0;  // write-only and unmapped offsets
    endcase
  end

  assign irq_o = |(status_q & mask_q);
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk
  import spi_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = IRQ_NUM_SRC,
  parameter int unsigned ADDR_W  = REG_ADDR_W,
  parameter int unsigned DATA_W  = REG_DATA_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_SRC-1:0] src_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] status_i,
  input logic [NUM_SRC-1:0] mask_i
);
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    p_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_i[b] |=> status_i[b]);
    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_i[b] && !(wr_i && addr_i == OFF_STATUS && wdata_i[b])) |=> status_i[b]);
    p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == OFF_STATUS && wdata_i[b] && !src_i[b]) |=> !status_i[b]);
    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == OFF_STATUS && wdata_i[b] && src_i[b]) |=> status_i[b]);
  end

  p_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_ENABLE) |=>
      ((mask_i & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));
  p_disable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_DISABLE) |=> ((mask_i & $past(wdata_i[NUM_SRC-1:0])) == '0));
  p_mask_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_MASK) |=> $stable(mask_i));
  p_wo_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_ENABLE || addr_i == OFF_DISABLE) |-> rdata_o == '0);
  p_irq_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_i != '0 && mask_i != '0));
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .src_i   (src_i),
  .irq_o   (irq_o),
  .status_i(status_q),
  .mask_i  (mask_q)
);

// File: tb/tb_spi_irq_ctrl.sv
module tb_spi_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [6:0]  src_i = '0;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [6:0] m_st = '0, m_mk = '0;

  spi_irq_ctrl dut (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st <= '0;
      m_mk <= '0;
    end else begin
      logic [6:0] s, k;
      s = m_st;
      k = m_mk;
      if (wr_i && addr_i == 6'h04) s = s & ~wdata_i[6:0];
      s = s | src_i;
      if (wr_i && addr_i == 6'h08) k = k | wdata_i[6:0];
      if (wr_i && addr_i == 6'h0C) k = k & ~wdata_i[6:0];
      m_st <= s;
      m_mk <= k;
    end
  end

  function automatic logic [31:0] m_read(logic [5:0] a);
    if (a == 6'h04) return {25'd0, m_st};
    if (a == 6'h10) return {25'd0, m_mk};
    return 32'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    #2;
    if (rst_ni && !done) begin
      chk("R10 irq", {31'd0, irq_o}, {31'd0, |(m_st & m_mk)});
      chk("R8 rdata", rdata_o, m_read(addr_i));
    end
  end

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    tick();
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic pulse(logic [6:0] s);
    src_i = s;
    tick();
    src_i = '0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    #10;
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    rd(6'h04, d); chk("R1 status", d, 32'h0);
    rd(6'h10, d); chk("R1 mask", d, 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'h0);

    pulse(7'h02);
    rd(6'h04, d); chk("R2 mode fault latched", d, 32'h02);
    tick();
    rd(6'h04, d); chk("R2 sticky", d, 32'h02);
    chk("R10 masked off", {31'd0, irq_o}, 32'h0);

    wr(6'h08, 32'h02);
    rd(6'h10, d); chk("R6 enable", d, 32'h02);
    chk("R10 irq on", {31'd0, irq_o}, 32'h1);
    wr(6'h08, 32'h40);
    rd(6'h10, d); chk("R6 zeros keep", d, 32'h42);

    rd(6'h08, d); chk("R9 enable reads 0", d, 32'h0);
    rd(6'h0C, d); chk("R9 disable reads 0", d, 32'h0);
    rd(6'h3C, d); chk("R9 unmapped reads 0", d, 32'h0);
    wr(6'h10, 32'h7F);
    rd(6'h10, d); chk("R9 mask read-only", d, 32'h42);

    pulse(7'h41);
    rd(6'h04, d); chk("R2 events", d, 32'h43);
    wr(6'h04, 32'h01);
    rd(6'h04, d); chk("R3 w1c", d, 32'h42);

    src_i = 7'h10;
    tick();
    wr(6'h04, 32'h10);
    rd(6'h04, d); chk("R5 level persists", d, 32'h52);
    src_i = 7'h00;
    tick();
    rd(6'h04, d); chk("R5 latched after drop", d, 32'h52);
    wr(6'h04, 32'h10);
    rd(6'h04, d); chk("R5 cleared", d, 32'h42);

    src_i = 7'h01;
    wr(6'h04, 32'h01);
    src_i = 7'h00;
    rd(6'h04, d); chk("R4 set wins", d, 32'h43);

    wr(6'h0C, 32'h02);
    rd(6'h10, d); chk("R7 disable", d, 32'h40);
    chk("R10 via bit6", {31'd0, irq_o}, 32'h1);
    wr(6'h04, 32'h40);
    chk("R10 irq drops", {31'd0, irq_o}, 32'h0);

    wr(6'h08, 32'hFFFF_FF80);
    rd(6'h10, d); chk("R11 upper enable bits", d, 32'h40);
    wr(6'h04, 32'hFFFF_FF80);
    rd(6'h04, d); chk("R11 upper clear bits", d, 32'h03);
    wr(6'h0C, 32'hFFFF_FF80);
    rd(6'h10, d); chk("R11 upper disable bits", d, 32'h40);

    tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule